// File: doc/BRIEF.md
# Segment Insertion Scan Cell

This block is a one-bit configuration element for an internal test data register chain that sits behind a standard JTAG TAP. It holds a shift stage and an update stage. The update stage decides whether a sub-segment of scan cells, leading to an embedded instrument, is spliced into the active chain or bypassed. Because of this, the scan length seen at the chain output changes at run time, depending on what was last written to the update stages.

The TAP supplies decoded capture, shift and update strobes on TCK, together with a synchronous test reset. The enclosing register supplies a select. When the cell is open (update stage = 1), serial data passes through the inserted segment first and then through the cell's own shift stage. The segment also receives gated copies of the select and strobes, so a closed instrument neither shifts nor updates. Several cells can be placed in series, each with its own instrument segment, to build a reconfigurable network.

Top module: `sib_scan_cell`

## Requirements
- R1: While `rst` is high at a rising TCK edge, the update stage and the shift stage are cleared to 0. After reset the segment is excluded, `seg_sel_o` is 0 and `tdo_o` is 0.
- R2: At a rising TCK edge with `sel_i`=1 and `shf_i`=1 (and `cap_i`=0), the shift stage loads `seg_tdo_i` when the cell is open and `tdi_i` when it is closed.
- R3: With `sel_i`=0, the capture, shift and update strobes have no effect: the shift and update stages keep their values.
- R4: The update stage loads the shift stage's value only at a rising edge with `sel_i`=1 and `upd_i`=1. Otherwise it holds.
- R5: At a rising edge with `sel_i`=1 and `cap_i`=1, the shift stage loads the current update-stage value (1 = open). This lets the open/closed status be shifted out.
- R6: When the cell is open, the chain order is `tdi_i`, then the segment, then the cell's own shift stage, then `tdo_o`. The cell's own bit is the last one shifted out.
- R7: `seg_sel_o`, `seg_cap_o`, `seg_shf_o` and `seg_upd_o` are asserted only while the cell is open and `sel_i` is 1. A closed segment keeps its update-stage contents.
- R8: `tdo_o` carries the shift stage's value and changes only on the falling TCK edge.
- R9: With two cells in series, each wrapping a 4-bit instrument register, the chain length from serial in to serial out is 2 bits with both closed, 6 bits with exactly one open, and 10 bits with both open.
- R10: `seg_tdi_o` always equals `tdi_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high test reset |
| sel_i | input | 1 | Select from the enclosing register |
| cap_i | input | 1 | Capture strobe from the TAP |
| shf_i | input | 1 | Shift strobe from the TAP |
| upd_i | input | 1 | Update strobe from the TAP |
| tdi_i | input | 1 | Serial data in |
| seg_tdo_i | input | 1 | Serial data returning from the inserted segment |
| tdo_o | output | 1 | Serial data out, retimed on the falling edge |
| seg_sel_o | output | 1 | Select toward the segment |
| seg_cap_o | output | 1 | Capture strobe toward the segment |
| seg_shf_o | output | 1 | Shift strobe toward the segment |
| seg_upd_o | output | 1 | Update strobe toward the segment |
| seg_tdi_o | output | 1 | Serial data toward the segment |

## Verification
The shift and update stages change at the rising edge that samples a strobe. `tdo_o` follows half a cycle later, at the falling edge. The segment strobes and `seg_tdi_o` are combinational in the same cycle. The bench drives inputs 1 ns after a falling edge. It checks `tdo_o` 1 ns after the rising edge, where the value must still be the old one, and again 1 ns after the falling edge, where the new value must appear. All other results are also compared at that falling-edge sample against a behavioural model of two cells and their instruments. Chain length is measured by flushing zeros and then counting the shifts a single 1 needs to reach the output.

// File: rtl/sib_pkg.sv
package sib_pkg;
  // Value the update stage takes on test reset: 0 = segment excluded.
  localparam logic UPD_RST = 1'b0;

  // Strobe bundle as seen by a scan segment.
  typedef struct packed {
    logic sel;
    logic cap;
    logic shf;
    logic upd;
  } dr_strb_t;
endpackage

// File: rtl/sib_shift_stage.sv
module sib_shift_stage (
  input  logic tck,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic shf_i,
  input  logic open_i,
  input  logic tdi_i,
  input  logic seg_tdo_i,
  output logic sr_o
);
  always_ff @(posedge tck) begin
    if (rst)
      sr_o <= 1'b0;
    else if (sel_i && cap_i)
      sr_o <= open_i;
    else if (sel_i && shf_i)
      sr_o <= open_i ? seg_tdo_i : tdi_i;
  end

  AST_SHF_HOLD: assert property (@(posedge tck) disable iff (rst)
    !(sel_i && (cap_i || shf_i)) |=> $stable(sr_o)); // R3
  AST_CAP_STATUS: assert property (@(posedge tck) disable iff (rst)
    (sel_i && cap_i) |=> (sr_o == $past(open_i))); // R5
  AST_SHF_SOURCE: assert property (@(posedge tck) disable iff (rst)
    (sel_i && shf_i && !cap_i && open_i) |=> (sr_o == $past(seg_tdo_i))); // R2
endmodule

// File: rtl/sib_update_stage.sv
module sib_update_stage
  import sib_pkg::*;
(
  input  logic tck,
  input  logic rst,
  input  logic sel_i,
  input  logic upd_i,
  input  logic sr_i,
  output logic open_o
);
  always_ff @(posedge tck) begin
    if (rst)
      open_o <= UPD_RST;
    else if (sel_i && upd_i)
      open_o <= sr_i;
  end

  AST_UPD_HOLD: assert property (@(posedge tck) disable iff (rst)
    !(sel_i && upd_i) |=> $stable(open_o)); // R4
  AST_UPD_LOAD: assert property (@(posedge tck) disable iff (rst)
    (sel_i && upd_i) |=> (open_o == $past(sr_i))); // R4
  AST_RST_CLOSED: assert property (@(posedge tck)
    rst |=> !open_o); // R1
endmodule

// File: rtl/sib_tdo_retime.sv
module sib_tdo_retime #(
  parameter bit NEG_EDGE = 1'b1
) (
  input  logic tck,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  generate
    if (NEG_EDGE) begin : g_neg
      always_ff @(negedge tck) begin
        if (rst) q_o <= 1'b0;
        else     q_o <= d_i;
      end

      AST_TDO_FALL: assert property (@(negedge tck) disable iff (rst)
        q_o == $past(d_i)); // R8
    end else begin : g_pass
      assign q_o = d_i;
    end
  endgenerate
endmodule

// File: rtl/sib_scan_cell.sv
module sib_scan_cell
  import sib_pkg::*;
#(
  parameter bit TDO_NEG_EDGE = 1'b1
) (
  input  logic tck,
  input  logic rst,
  input  logic sel_i,
  input  logic cap_i,
  input  logic shf_i,
  input  logic upd_i,
  input  logic tdi_i,
  input  logic seg_tdo_i,
  output logic tdo_o,
  output logic seg_sel_o,
  output logic seg_cap_o,
  output logic seg_shf_o,
  output logic seg_upd_o,
  output logic seg_tdi_o
);
  logic     shift_q;
  logic     open_q;
  dr_strb_t seg_s;

  sib_shift_stage u_shift (
    .tck       (tck),
    .rst       (rst),
    .sel_i     (sel_i),
    .cap_i     (cap_i),
    .shf_i     (shf_i),
    .open_i    (open_q),
    .tdi_i     (tdi_i),
    .seg_tdo_i (seg_tdo_i),
    .sr_o      (shift_q)
  );

  sib_update_stage u_update (
    .tck    (tck),
    .rst    (rst),
    .sel_i  (sel_i),
    .upd_i  (upd_i),
    .sr_i   (shift_q),
    .open_o (open_q)
  );

  sib_tdo_retime #(.NEG_EDGE(TDO_NEG_EDGE)) u_retime (
    .tck (tck),
    .rst (rst),
    .d_i (shift_q),
    .q_o (tdo_o)
  );

  // Segment strobes exist only while this cell is open and selected.
  always_comb begin
    seg_s.sel = sel_i & open_q;
    seg_s.cap = seg_s.sel & cap_i;
    seg_s.shf = seg_s.sel & shf_i;
    seg_s.upd = seg_s.sel & upd_i;
  end

  assign seg_sel_o = seg_s.sel;
  assign seg_cap_o = seg_s.cap;
  assign seg_shf_o = seg_s.shf;
  assign seg_upd_o = seg_s.upd;
  assign seg_tdi_o = tdi_i;

  AST_SEG_QUIET_CLOSED: assert property (@(posedge tck) disable iff (rst)
    (!open_q || !sel_i) |-> !(seg_sel_o || seg_cap_o || seg_shf_o || seg_upd_o)); // R7
  AST_CLOSED_PASS: assert property (@(posedge tck) disable iff (rst)
    (sel_i && shf_i && !cap_i && !open_q) |=> (shift_q == $past(tdi_i))); // R6
endmodule

// File: tb/sim_sib_scan_cell.sv
`timescale 1ns/1ps
module sim_sib_scan_cell;
  logic tck = 1'b0;
  always #2 tck = ~tck;

  logic rst = 1'b1, sel = 1'b0, cap = 1'b0, shf = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic a_tdo, a_sel, a_cap, a_shf, a_upd, a_stdi, a_stdo;
  logic b_tdo, b_sel, b_cap, b_shf, b_upd, b_stdi, b_stdo;
  logic [3:0] ia_sh, ia_up, ib_sh, ib_up;

  int checks = 0;
  int errors = 0;

  sib_scan_cell u0 (
    .tck(tck), .rst(rst), .sel_i(sel), .cap_i(cap), .shf_i(shf), .upd_i(upd),
    .tdi_i(tdi), .seg_tdo_i(a_stdo), .tdo_o(a_tdo), .seg_sel_o(a_sel),
    .seg_cap_o(a_cap), .seg_shf_o(a_shf), .seg_upd_o(a_upd), .seg_tdi_o(a_stdi)
  );

  sib_scan_cell u1 (
    .tck(tck), .rst(rst), .sel_i(sel), .cap_i(cap), .shf_i(shf), .upd_i(upd),
    .tdi_i(a_tdo), .seg_tdo_i(b_stdo), .tdo_o(b_tdo), .seg_sel_o(b_sel),
    .seg_cap_o(b_cap), .seg_shf_o(b_shf), .seg_upd_o(b_upd), .seg_tdi_o(b_stdi)
  );

  // Small instrument registers: 4-bit shift, in at bit 3, out from bit 0.
  always_ff @(posedge tck) begin
    if (rst) begin
      ia_sh <= 4'b0110; ia_up <= 4'b0000;
      ib_sh <= 4'b1001; ib_up <= 4'b0000;
    end else begin
      if (a_sel && a_shf) ia_sh <= {a_stdi, ia_sh[3:1]};
      if (a_upd)          ia_up <= ia_sh;
      if (b_sel && b_shf) ib_sh <= {b_stdi, ib_sh[3:1]};
      if (b_upd)          ib_up <= ib_sh;
    end
  end
  assign a_stdo = ia_sh[0];
  assign b_stdo = ib_sh[0];

  // Behavioural reference model of the two-cell network.
  bit m_oa, m_ob, m_sa, m_sb;
  bit [3:0] m_ia, m_ib, m_iau, m_ibu;

  task automatic model_step(bit r, bit s, bit c, bit h, bit u, bit d);
    bit oa, ob, sa, sb;
    bit [3:0] ia, ib;
    oa = m_oa; ob = m_ob; sa = m_sa; sb = m_sb; ia = m_ia; ib = m_ib;
    if (r) begin
      m_oa = 0; m_ob = 0; m_sa = 0; m_sb = 0;
      m_ia = 4'b0110; m_ib = 4'b1001; m_iau = 0; m_ibu = 0;
      return;
    end
    if (s && c) begin
      m_sa = oa; m_sb = ob;
    end else if (s && h) begin
      if (oa) begin m_ia = {d, ia[3:1]}; m_sa = ia[0]; end else m_sa = d;
      if (ob) begin m_ib = {sa, ib[3:1]}; m_sb = ib[0]; end else m_sb = sa;
    end
    if (s && u) begin
      m_oa = sa; m_ob = sb;
      if (oa) m_iau = ia;
      if (ob) m_ibu = ib;
    end
  endtask

  task automatic chk(int act, int exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One TCK cycle: drive after a falling edge, check both edges.
  task automatic cyc(bit r, bit s, bit c, bit h, bit u, bit d);
    bit prev;
    rst = r; sel = s; cap = c; shf = h; upd = u; tdi = d;
    prev = m_sb;
    @(posedge tck);
    model_step(r, s, c, h, u, d);
    #1;
    chk(b_tdo, prev, "R8 tdo unchanged after rising edge");
    @(negedge tck);
    #1;
    chk(b_tdo, m_sb, "R6 chain output");
    chk(a_tdo, m_sa, "R2 first cell shift stage");
    chk(a_sel, s & m_oa, "R7 first segment select");
    chk(b_sel, s & m_ob, "R7 second segment select");
    chk(a_upd, s & u & m_oa, "R7 first segment update gating");
    chk(b_shf, s & h & m_ob, "R7 second segment shift gating");
    chk(ia_up, m_iau, "R7 first instrument update contents");
    chk(ib_up, m_ibu, "R7 second instrument update contents");
    chk(a_stdi, d, "R10 segment data in");
    chk(b_stdi, m_sa, "R10 segment data in second cell");
  endtask

  task automatic shift_in(bit d);
    cyc(0, 1, 0, 1, 0, d);
  endtask

  // Reset, then open the cells as requested (second cell's bit enters first).
  task automatic configure(bit oa, bit ob);
    cyc(1, 0, 0, 0, 0, 0);
    shift_in(ob);
    shift_in(oa);
    cyc(0, 1, 0, 0, 1, 0);
    chk(a_sel, oa, "R4 first cell opened by update");
    chk(b_sel, ob, "R4 second cell opened by update");
  endtask

  task automatic measure(int exp_len, string tag);
    int n = 0;
    for (int i = 0; i < 12; i++) shift_in(1'b0);
    for (int i = 1; i <= 16; i++) begin
      shift_in(i == 1);
      if (n == 0 && b_tdo === 1'b1) n = i;
    end
    chk(n, exp_len, tag);
  endtask

  initial begin : main
    bit [3:0] held;
    rst = 1; sel = 1;
    repeat (3) @(negedge tck);
    #1;
    model_step(1, 0, 0, 0, 0, 0);
    chk(b_tdo, 0, "R1 tdo after reset");
    chk(a_sel, 0, "R1 segment select low after reset");
    chk(b_sel, 0, "R1 segment select low after reset");
    rst = 0; sel = 0;

    // R3: strobes ignored while unselected.
    cyc(0, 0, 0, 1, 0, 1);
    cyc(0, 0, 0, 1, 0, 1);
    chk(a_tdo, 0, "R3 shift ignored without select");
    cyc(0, 0, 1, 0, 1, 1);
    chk(a_sel | b_sel, 0, "R3 update ignored without select");

    // R9: chain length for all four combinations.
    configure(0, 0); measure(2,  "R9 length both closed");
    configure(1, 0); measure(6,  "R9 length first open");
    configure(0, 1); measure(6,  "R9 length second open");
    configure(1, 1); measure(10, "R9 length both open");

    // R5: capture reads back status; own bit comes out last (R6).
    configure(1, 0);
    cyc(0, 1, 1, 0, 0, 0);
    chk(a_tdo, 1, "R5 captured open status");
    chk(b_tdo, 0, "R5 captured closed status");
    for (int i = 0; i < 6; i++) shift_in(i[0]);

    // R7: a closed segment keeps its update contents.
    configure(1, 1);
    for (int i = 0; i < 10; i++) shift_in(i % 3 == 0);
    cyc(0, 1, 0, 0, 1, 0);
    configure(0, 1);
    held = ia_up;
    for (int i = 0; i < 6; i++) shift_in(1'b1);
    cyc(0, 1, 0, 0, 1, 0);
    chk(ia_up, held, "R7 closed instrument update held");

    // Load a pattern into the second instrument while it stays open.
    configure(0, 1);
    shift_in(1); shift_in(1); shift_in(0); shift_in(0); shift_in(1); shift_in(0);
    cyc(0, 1, 0, 0, 1, 0);
    chk(b_sel, 1, "R4 second cell remains open");
    cyc(0, 1, 1, 0, 0, 0);
    for (int i = 0; i < 6; i++) shift_in(1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule